// File: doc/BRIEF.md
# Guest Trap Redirection Unit

This unit takes a trap that the core has already selected, given as an interrupt flag and a cause index. It decides whether a virtualized guest's supervisor level should handle the trap. A trap goes to the guest when it is delegated to the guest, or when it is a virtual interrupt injected by the hypervisor. The unit then works out two values: the cause word the guest will see, and the program counter the guest handler starts from, taken from the guest trap-vector register.

Legacy guest interrupts (software, timer and external) appear to the guest one cause number lower, so that they look like ordinary supervisor interrupts. An injected interrupt bypasses the delegation mask and keeps its identifier unchanged. The result is registered once, so outputs reflect the inputs of the previous clock. The unit does not update any other state on trap entry.

Top module: `guest_trap_redir`

## Requirements
- R1: A trap is taken by the guest when `virt_on` is 1, `cur_priv` is user (2'b00) or supervisor (2'b01), `trap_idx` is below XLEN, and bit `trap_idx` of `guest_deleg` is 1.
- R2: The delegation mask has no effect when `virt_on` is 0 or `cur_priv` is machine (2'b11). In those cases a trap is taken only through injection.
- R3: A cause index at or above XLEN is never taken through the delegation mask.
- R4: An injection is recognised when `inj_en` is 1, `inj_id` equals `trap_idx`, and `guest_top_id` equals `trap_idx`. An injected trap is taken whatever the privilege, the virtualization flag and the mask.
- R5: An injection whose identifier is 9 (supervisor external) is not recognised.
- R6: For an interrupt that is not injected and whose index is at most 10, the adjusted cause is the index minus one.
- R7: Exceptions, interrupts with an index above 10, and injected interrupts keep their index unchanged as the adjusted cause.
- R8: `guest_cause` is the adjusted cause, with bit XLEN-1 set if and only if the trap is an interrupt.
- R9: `guest_pc` is `gvec_base` with bit 0 cleared. Four times the adjusted cause is added to it only when `gvec_base` bit 0 (vectored mode) is 1 and the trap is an interrupt.
- R10: When the trap is not taken by the guest, `guest_take`, `guest_cause` and `guest_pc` are all zero.
- R11: The outputs are registered. They reflect the inputs present at the previous rising edge of `clk`, and they are zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_irq | input | 1 | 1 when the selected trap is an interrupt |
| trap_idx | input | 12 | Cause index of the selected trap |
| cur_priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt_on | input | 1 | Virtualization active |
| guest_deleg | input | 64 | Guest delegation mask, one bit per cause index |
| inj_en | input | 1 | Virtual interrupt injection enable |
| inj_id | input | 12 | Identifier of the injected interrupt |
| guest_top_id | input | 12 | Identifier of the guest's highest pending interrupt |
| gvec_base | input | 64 | Guest trap-vector base; bit 0 selects vectored mode |
| guest_take | output | 1 | Trap is taken by the guest |
| guest_cause | output | 64 | Guest-visible cause word |
| guest_pc | output | 64 | Guest handler address |

## Verification
The bench covers the boundaries of the shift. Index 10 must come out as 9, and index 13 must stay 13. A design that compared with "below" instead of "at most" would give the guest-external interrupt the wrong cause. Injection is tested with a zeroed mask, at machine privilege and at an index above XLEN, to show that it bypasses delegation and is never shifted. Its near misses (a mismatched top identifier, the enable bit low, identifier 9) must not be taken. Exceptions in vectored mode and interrupts in direct mode both land on the bare base address, and untaken traps must leave all outputs at zero.

// File: rtl/gtr_pkg.sv
package gtr_pkg;
    localparam int XLEN_DEF = 64;
    localparam int IDW_DEF  = 12;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    // Interrupt identifiers the unit treats specially
    localparam int IID_SUP_EXT   = 9;
    localparam int IID_GUEST_EXT = 10;
endpackage

// File: rtl/gtr_decide.sv
module gtr_decide #(
    parameter int XLEN = gtr_pkg::XLEN_DEF,
    parameter int IDW  = gtr_pkg::IDW_DEF
) (
    input  logic [IDW-1:0]  trap_idx,
    input  logic [1:0]      cur_priv,
    input  logic            virt_on,
    input  logic [XLEN-1:0] guest_deleg,
    input  logic            inj_en,
    input  logic [IDW-1:0]  inj_id,
    input  logic [IDW-1:0]  guest_top_id,
    output logic            deleg_hit,
    output logic            inject_hit
);
    localparam int SELW = $clog2(XLEN);
    localparam logic [IDW-1:0] XLEN_IDX = IDW'(XLEN);
    localparam logic [IDW-1:0] SEXT_IDX = IDW'(gtr_pkg::IID_SUP_EXT);

    logic low_priv;
    logic in_range;

    always_comb begin
        low_priv   = (cur_priv == gtr_pkg::PRIV_U) || (cur_priv == gtr_pkg::PRIV_S);
        in_range   = trap_idx < XLEN_IDX;
        deleg_hit  = virt_on && low_priv && in_range
                     && guest_deleg[trap_idx[SELW-1:0]];
        inject_hit = inj_en && (inj_id != SEXT_IDX)
                     && (inj_id == trap_idx) && (guest_top_id == trap_idx);
    end
endmodule

// File: rtl/gtr_cause.sv
module gtr_cause #(
    parameter int XLEN = gtr_pkg::XLEN_DEF,
    parameter int IDW  = gtr_pkg::IDW_DEF
) (
    input  logic            trap_irq,
    input  logic [IDW-1:0]  trap_idx,
    input  logic            inject_hit,
    output logic [XLEN-1:0] adj_cause,
    output logic [XLEN-1:0] cause_word
);
    localparam logic [IDW-1:0] GEXT_IDX = IDW'(gtr_pkg::IID_GUEST_EXT);

    logic shift_down;

    always_comb begin
        shift_down = trap_irq && !inject_hit && (trap_idx <= GEXT_IDX);
        adj_cause  = shift_down ? (XLEN'(trap_idx) - XLEN'(1)) : XLEN'(trap_idx);
        cause_word = adj_cause;
        cause_word[XLEN-1] = adj_cause[XLEN-1] | trap_irq;
    end
endmodule

// File: rtl/gtr_target.sv
module gtr_target #(
    parameter int XLEN = gtr_pkg::XLEN_DEF
) (
    input  logic            trap_irq,
    input  logic [XLEN-1:0] gvec_base,
    input  logic [XLEN-1:0] adj_cause,
    output logic [XLEN-1:0] target_pc
);
    logic [XLEN-1:0] aligned;
    logic [XLEN-1:0] offset;

    always_comb begin
        aligned   = {gvec_base[XLEN-1:1], 1'b0};
        offset    = (gvec_base[0] && trap_irq) ? {adj_cause[XLEN-3:0], 2'b00} : '0;
        target_pc = aligned + offset;
    end
endmodule

// File: rtl/guest_trap_redir.sv
module guest_trap_redir #(
    parameter int XLEN = gtr_pkg::XLEN_DEF,
    parameter int IDW  = gtr_pkg::IDW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_irq,
    input  logic [IDW-1:0]  trap_idx,
    input  logic [1:0]      cur_priv,
    input  logic            virt_on,
    input  logic [XLEN-1:0] guest_deleg,
    input  logic            inj_en,
    input  logic [IDW-1:0]  inj_id,
    input  logic [IDW-1:0]  guest_top_id,
    input  logic [XLEN-1:0] gvec_base,
    output logic            guest_take,
    output logic [XLEN-1:0] guest_cause,
    output logic [XLEN-1:0] guest_pc
);
    localparam logic [IDW-1:0] XLEN_IDX = IDW'(XLEN);
    localparam logic [IDW-1:0] SEXT_IDX = IDW'(gtr_pkg::IID_SUP_EXT);
    localparam logic [IDW-1:0] GEXT_IDX = IDW'(gtr_pkg::IID_GUEST_EXT);

    typedef struct packed {
        logic            take;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] pc;
    } redir_t;

    redir_t st_d, st_q;

    logic            deleg_hit;
    logic            inject_hit;
    logic [XLEN-1:0] adj_cause;
    logic [XLEN-1:0] cause_word;
    logic [XLEN-1:0] target_pc;

    gtr_decide #(.XLEN(XLEN), .IDW(IDW)) u_decide (
        .trap_idx    (trap_idx),
        .cur_priv    (cur_priv),
        .virt_on     (virt_on),
        .guest_deleg (guest_deleg),
        .inj_en      (inj_en),
        .inj_id      (inj_id),
        .guest_top_id(guest_top_id),
        .deleg_hit   (deleg_hit),
        .inject_hit  (inject_hit)
    );

    gtr_cause #(.XLEN(XLEN), .IDW(IDW)) u_cause (
        .trap_irq  (trap_irq),
        .trap_idx  (trap_idx),
        .inject_hit(inject_hit),
        .adj_cause (adj_cause),
        .cause_word(cause_word)
    );

    gtr_target #(.XLEN(XLEN)) u_target (
        .trap_irq (trap_irq),
        .gvec_base(gvec_base),
        .adj_cause(adj_cause),
        .target_pc(target_pc)
    );

    always_comb begin
        st_d = '0;
        if (deleg_hit || inject_hit) begin
            st_d.take  = 1'b1;
            st_d.cause = cause_word;
            st_d.pc    = target_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign guest_take  = st_q.take;
    assign guest_cause = st_q.cause;
    assign guest_pc    = st_q.pc;

    AST_DELEG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (virt_on && cur_priv != 2'b11 && cur_priv != 2'b10 && trap_idx < XLEN_IDX
         && guest_deleg[trap_idx[$clog2(XLEN)-1:0]]) |=> guest_take); // R1
    AST_MPRIV_IGNORES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == 2'b11 && !inject_hit) |=> !guest_take); // R2
    AST_WIDE_IDX_NOT_DELEG: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_idx >= XLEN_IDX && !inject_hit) |=> !guest_take); // R3
    AST_INJECT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_en && inj_id == trap_idx && guest_top_id == trap_idx && trap_idx != SEXT_IDX)
        |=> guest_take); // R4
    AST_SEXT_NOT_INJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_id == SEXT_IDX && !deleg_hit) |=> !guest_take); // R5
    AST_LEGACY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_irq && !inject_hit && deleg_hit && trap_idx <= GEXT_IDX && trap_idx != '0)
        |=> (guest_cause[XLEN-2:0] == (XLEN-1)'($past(trap_idx)) - (XLEN-1)'(1))); // R6
    AST_EXC_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (guest_take && !$past(trap_irq)) |-> (guest_cause == XLEN'($past(trap_idx)))); // R7
    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        guest_take |-> (guest_cause[XLEN-1] == $past(trap_irq))); // R8
    AST_PC_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        guest_take |-> (guest_pc[1:0] == {$past(gvec_base[1]), 1'b0})); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !guest_take |-> (guest_cause == '0 && guest_pc == '0)); // R10
endmodule

// File: tb/guest_trap_redir_bench.sv
module guest_trap_redir_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam logic [63:0] IB = 64'h8000_0000_0000_0000;
    localparam logic [63:0] BV = 64'h0000_0000_8000_1001; // vectored
    localparam logic [63:0] BD = 64'h0000_0000_8000_2000; // direct

    typedef struct packed {
        logic        irq;
        logic [11:0] idx;
        logic [1:0]  priv;
        logic        virt;
        logic [63:0] deleg;
        logic        inj;
        logic [11:0] vid;
        logic [11:0] gtop;
        logic [63:0] base;
        logic        e_take;
        logic [63:0] e_cause;
        logic [63:0] e_pc;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 12'd2,  2'b01, 1'b1, 64'h4,   1'b0, 12'd0,  12'd0,  BV, 1'b1, IB | 64'd1,  64'h8000_1004, "R6 "},
        '{1'b1, 12'd10, 2'b00, 1'b1, 64'h400, 1'b0, 12'd0,  12'd0,  BV, 1'b1, IB | 64'd9,  64'h8000_1024, "R6 "},
        '{1'b0, 12'd21, 2'b00, 1'b1, 64'h20_0000, 1'b0, 12'd0, 12'd0, BV, 1'b1, 64'd21,    64'h8000_1000, "R7 "},
        '{1'b1, 12'd13, 2'b01, 1'b1, 64'h2000, 1'b0, 12'd0, 12'd0,  BV, 1'b1, IB | 64'd13, 64'h8000_1034, "R7 "},
        '{1'b1, 12'd6,  2'b01, 1'b1, 64'h40,  1'b0, 12'd0,  12'd0,  BD, 1'b1, IB | 64'd5,  64'h8000_2000, "R9 "},
        '{1'b1, 12'd2,  2'b11, 1'b1, '1,      1'b0, 12'd0,  12'd0,  BV, 1'b0, 64'd0,       64'd0,         "R2 "},
        '{1'b1, 12'd2,  2'b01, 1'b0, 64'h4,   1'b0, 12'd0,  12'd0,  BV, 1'b0, 64'd0,       64'd0,         "R2 "},
        '{1'b1, 12'd2,  2'b01, 1'b1, 64'hFFFB, 1'b0, 12'd0, 12'd0,  BV, 1'b0, 64'd0,       64'd0,         "R1 "},
        '{1'b1, 12'd5,  2'b01, 1'b1, 64'd0,   1'b1, 12'd5,  12'd5,  BV, 1'b1, IB | 64'd5,  64'h8000_1014, "R4 "},
        '{1'b1, 12'd9,  2'b01, 1'b1, 64'd0,   1'b1, 12'd9,  12'd9,  BV, 1'b0, 64'd0,       64'd0,         "R5 "},
        '{1'b1, 12'd5,  2'b01, 1'b1, 64'd0,   1'b1, 12'd5,  12'd6,  BV, 1'b0, 64'd0,       64'd0,         "R4 "},
        '{1'b1, 12'd5,  2'b11, 1'b0, 64'd0,   1'b1, 12'd5,  12'd5,  BV, 1'b1, IB | 64'd5,  64'h8000_1014, "R4 "},
        '{1'b1, 12'd64, 2'b00, 1'b1, '1,      1'b0, 12'd0,  12'd0,  BV, 1'b0, 64'd0,       64'd0,         "R3 "},
        '{1'b1, 12'd70, 2'b01, 1'b1, 64'd0,   1'b1, 12'd70, 12'd70, BV, 1'b1, IB | 64'd70, 64'h8000_1118, "R7 "},
        '{1'b1, 12'd5,  2'b01, 1'b1, 64'd0,   1'b0, 12'd5,  12'd5,  BV, 1'b0, 64'd0,       64'd0,         "R4 "}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_irq = 1'b0;
    logic [11:0] trap_idx = '0;
    logic [1:0]  cur_priv = 2'b00;
    logic        virt_on = 1'b0;
    logic [63:0] guest_deleg = '0;
    logic        inj_en = 1'b0;
    logic [11:0] inj_id = '0;
    logic [11:0] guest_top_id = '0;
    logic [63:0] gvec_base = '0;
    logic        guest_take;
    logic [63:0] guest_cause;
    logic [63:0] guest_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    guest_trap_redir u_guest_trap_redir (
        .clk(clk), .rst_n(rst_n), .trap_irq(trap_irq), .trap_idx(trap_idx),
        .cur_priv(cur_priv), .virt_on(virt_on), .guest_deleg(guest_deleg),
        .inj_en(inj_en), .inj_id(inj_id), .guest_top_id(guest_top_id),
        .gvec_base(gvec_base), .guest_take(guest_take),
        .guest_cause(guest_cause), .guest_pc(guest_pc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        trap_irq = v.irq; trap_idx = v.idx; cur_priv = v.priv; virt_on = v.virt;
        guest_deleg = v.deleg; inj_en = v.inj; inj_id = v.vid;
        guest_top_id = v.gtop; gvec_base = v.base;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        // R11: outputs at zero during reset
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset take", {63'd0, guest_take}, 64'd0);
        chk("R11 reset cause", guest_cause, 64'd0);
        chk("R11 reset pc", guest_pc, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            @(posedge clk);
            #1;
            chk({string'(TBL[i].tag), "take"}, {63'd0, guest_take}, {63'd0, TBL[i].e_take});
            chk({string'(TBL[i].tag), "R8 R10 cause"}, guest_cause, TBL[i].e_cause);
            chk({string'(TBL[i].tag), "R9 R10 pc"}, guest_pc, TBL[i].e_pc);
        end

        // R11: one-cycle latency: new inputs not visible before the edge
        apply(TBL[0]);
        @(posedge clk);
        apply(TBL[5]);
        #1;
        chk("R11 latency hold", {63'd0, guest_take}, 64'd1);
        @(posedge clk);
        #1;
        chk("R11 latency update", {63'd0, guest_take}, 64'd0);

        // R11: reset mid-run clears a taken result
        apply(TBL[1]);
        @(posedge clk);
        #1;
        chk("R11 pre-reset take", {63'd0, guest_take}, 64'd1);
        rst_n = 1'b0;
        #1;
        chk("R11 async reset pc", guest_pc, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end
endmodule